// File: doc/BRIEF.md
# Range-Adaptive Pipelined Booth Multiplier

This block multiplies two signed 16-bit operands and returns the full signed 32-bit product. Before it forms any partial products, it inspects the pair and picks a precision. A pair in which both values fit in 4 signed bits runs as a 4-bit multiply. A pair in which both fit in 8 signed bits runs as an 8-bit multiply. Every other pair takes the full 16-bit path. The chosen precision travels down the pipeline beside the data. Later stages use it to hold unused radix-4 Booth rows and unused reduction sections at zero. This models operand isolation, which cuts switching activity on narrow data.

The pipeline has three register stages:

1. Precision detection and Booth recoding.
2. Sectioned partial-product reduction.
3. Final carry-propagate addition, built from 4-bit slices.

It takes a new operand pair on every clock cycle. The latency is the same in every precision, so a host sees the block as a plain fixed-latency multiplier. The precision is also brought out on an output port, so that the detection can be observed.

Top module: `range_booth_mul`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the signed product of the two operands that were accepted three cycles earlier, as a two's complement 32-bit value.
- R2: `out_valid` is high exactly three clock cycles after a cycle in which `in_valid` was high, and is low otherwise.
- R3: `out_prec` is 0 (4-bit precision) for an operation in which both operands lie in the range -8 to 7.
- R4: `out_prec` is 1 (8-bit precision) for an operation in which both operands lie in the range -128 to 127, and at least one of them lies outside -8 to 7.
- R5: `out_prec` is 2 (16-bit precision) for an operation in which at least one operand lies outside -128 to 127. The value 3 never appears on `out_prec`.
- R6: A new operation can be accepted on every cycle. Back-to-back operations each produce their own correct result on consecutive cycles.
- R7: In 4-bit precision only Booth rows 0 and 1 may be non-zero. In 8-bit precision only rows 0 to 3 may be non-zero. The product must still equal the full-precision result.
- R8: When `rst` is high at a clock edge, `out_valid`, `out_prec` and `out_prod` are cleared to 0 after that edge.
- R9: In a cycle where `out_valid` is low, `out_prod` and `out_prec` keep the values they held in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The operand pair on `op_a`/`op_b` is to be multiplied |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier (Booth-recoded) |
| out_valid | output | 1 | `out_prod` and `out_prec` carry a fresh result |
| out_prec | output | 2 | Precision used: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit |
| out_prod | output | 32 | Signed 32-bit product |

## Verification
A misjudged range shows up in two ways. If the detector picks a precision that is too narrow, it zeroes Booth rows that still carry information, and the product comes out wrong three cycles later. If it picks one that is too wide, the product is right but `out_prec` disagrees with the expected class, also three cycles later. A valid bit dropped or duplicated inside the pipeline shows up as a missing or extra `out_valid` pulse, or as a held result that changes during a bubble. For this reason, stimulus mixes operands drawn from each range class, operands placed at the class boundaries, back-to-back streams and bubbles.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [1:0] {
    PREC4  = 2'd0,
    PREC8  = 2'd1,
    PREC16 = 2'd2
  } prec_e;
endpackage

// File: rtl/rbm_range_detect.sv
module rbm_range_detect #(
  parameter int W   = 16,
  parameter int LO  = 4,
  parameter int MID = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output rbm_pkg::prec_e prec
);
  import rbm_pkg::*;

  // an operand fits n signed bits when bits [W-1:n-1] are all copies of one value
  logic a_lo, b_lo, a_mid, b_mid;
  assign a_lo  = (&a[W-1:LO-1])  | ~(|a[W-1:LO-1]);
  assign b_lo  = (&b[W-1:LO-1])  | ~(|b[W-1:LO-1]);
  assign a_mid = (&a[W-1:MID-1]) | ~(|a[W-1:MID-1]);
  assign b_mid = (&b[W-1:MID-1]) | ~(|b[W-1:MID-1]);

  always_comb begin
    if (a_lo && b_lo)        prec = PREC4;
    else if (a_mid && b_mid) prec = PREC8;
    else                     prec = PREC16;
  end
endmodule

// File: rtl/rbm_booth_rows.sv
module rbm_booth_rows #(
  parameter int W   = 16,
  parameter int LO  = 4,
  parameter int MID = 8,
  localparam int PW   = 2 * W,
  localparam int ROWS = W / 2
) (
  input  logic [W-1:0]              a,
  input  logic [W-1:0]              b,
  input  rbm_pkg::prec_e            prec,
  output logic [ROWS-1:0][PW-1:0]   rows
);
  import rbm_pkg::*;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] a_dbl;
  assign a_ext = {{W{a[W-1]}}, a};
  assign a_dbl = a_ext << 1;

  int unsigned lim;
  always_comb begin
    case (prec)
      PREC4:   lim = LO / 2;
      PREC8:   lim = MID / 2;
      default: lim = ROWS;
    endcase
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [2:0]    grp;
    logic [PW-1:0] pp;
    if (i == 0) begin : g_first
      assign grp = {b[1], b[0], 1'b0};
    end else begin : g_rest
      assign grp = {b[2*i+1], b[2*i], b[2*i-1]};
    end
    always_comb begin
      case (grp)
        3'b001, 3'b010: pp = a_ext;
        3'b011:         pp = a_dbl;
        3'b100:         pp = -a_dbl;
        3'b101, 3'b110: pp = -a_ext;
        default:        pp = '0;
      endcase
    end
    // rows beyond the active precision are isolated (held at zero)
    assign rows[i] = (i < lim) ? (pp << (2 * i)) : '0;
  end
endmodule

// File: rtl/rbm_reduce.sv
module rbm_reduce #(
  parameter int W   = 16,
  parameter int LO  = 4,
  parameter int MID = 8,
  localparam int PW    = 2 * W,
  localparam int ROWS  = W / 2,
  localparam int PAIRS = ROWS / 2,
  localparam int HALF  = PAIRS / 2
) (
  input  logic [ROWS-1:0][PW-1:0] rows,
  input  rbm_pkg::prec_e          prec,
  output logic [PW-1:0]           lo_sum,
  output logic [PW-1:0]           hi_sum
);
  import rbm_pkg::*;

  int unsigned lim;
  always_comb begin
    case (prec)
      PREC4:   lim = LO / 2;
      PREC8:   lim = MID / 2;
      default: lim = ROWS;
    endcase
  end

  logic [PAIRS-1:0][PW-1:0] sec;
  for (genvar j = 0; j < PAIRS; j++) begin : g_sec
    // a tree section is switched off when neither of its rows is in use
    assign sec[j] = ((2 * j) < lim) ? (rows[2*j] + rows[2*j+1]) : '0;
  end

  always_comb begin
    lo_sum = '0;
    hi_sum = '0;
    for (int j = 0; j < PAIRS; j++) begin
      if (j < HALF) lo_sum = lo_sum + sec[j];
      else          hi_sum = hi_sum + sec[j];
    end
  end
endmodule

// File: rtl/rbm_nibble_add.sv
module rbm_nibble_add #(
  parameter int PW  = 32,
  parameter int NIB = 4,
  localparam int SL = PW / NIB
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] s
);
  logic [SL:0] c;
  assign c[0] = 1'b0;
  for (genvar k = 0; k < SL; k++) begin : g_slice
    assign {c[k+1], s[k*NIB +: NIB]} = {1'b0, x[k*NIB +: NIB]} + {1'b0, y[k*NIB +: NIB]} + {{NIB{1'b0}}, c[k]};
  end
endmodule

// File: rtl/range_booth_mul.sv
module range_booth_mul #(
  parameter int W   = 16,
  parameter int LO  = 4,
  parameter int MID = 8,
  parameter int NIB = 4,
  localparam int PW   = 2 * W,
  localparam int ROWS = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output logic          out_valid,
  output logic [1:0]    out_prec,
  output logic [PW-1:0] out_prod
);
  import rbm_pkg::*;

  // stage 1: range detection and Booth recoding
  prec_e                  det_prec;
  logic [ROWS-1:0][PW-1:0] rows_c;

  rbm_range_detect #(.W(W), .LO(LO), .MID(MID)) u_det (
    .a(op_a), .b(op_b), .prec(det_prec)
  );

  rbm_booth_rows #(.W(W), .LO(LO), .MID(MID)) u_rows (
    .a(op_a), .b(op_b), .prec(det_prec), .rows(rows_c)
  );

  logic                    s1_v;
  prec_e                   s1_prec;
  logic [ROWS-1:0][PW-1:0] s1_rows;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_prec <= PREC4;
      s1_rows <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_prec <= det_prec;
        s1_rows <= rows_c;
      end
    end
  end

  // stage 2: sectioned reduction
  logic [PW-1:0] lo_c, hi_c;
  rbm_reduce #(.W(W), .LO(LO), .MID(MID)) u_red (
    .rows(s1_rows), .prec(s1_prec), .lo_sum(lo_c), .hi_sum(hi_c)
  );

  logic          s2_v;
  prec_e         s2_prec;
  logic [PW-1:0] s2_lo, s2_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v    <= 1'b0;
      s2_prec <= PREC4;
      s2_lo   <= '0;
      s2_hi   <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_prec <= s1_prec;
        s2_lo   <= lo_c;
        s2_hi   <= hi_c;
      end
    end
  end

  // stage 3: final add in 4-bit slices, registered outputs
  logic [PW-1:0] sum_c;
  rbm_nibble_add #(.PW(PW), .NIB(NIB)) u_add (
    .x(s2_lo), .y(s2_hi), .s(sum_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prec  <= 2'd0;
      out_prod  <= '0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) begin
        out_prec <= s2_prec;
        out_prod <= sum_c;
      end
    end
  end

  // checks
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  logic signed [PW-1:0] ref_prod;
  assign ref_prod = $signed(op_a) * $signed(op_b);

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid) |-> out_prod == $past(ref_prod, 3));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> out_valid == $past(in_valid, 3));

  assert_prec_legal_R5: assert property (@(posedge clk) disable iff (rst)
    out_prec != 2'd3);

  assert_rows_off8_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_prec != PREC16) |-> s1_rows[ROWS-1] == '0);

  assert_rows_off4_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_prec == PREC4) |-> s1_rows[LO/2] == '0);

  assert_hi_tree_off_R7: assert property (@(posedge clk) disable iff (rst)
    (s2_v && s2_prec != PREC16) |-> s2_hi == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |-> (out_prod == $past(out_prod) && out_prec == $past(out_prec)));
endmodule

// File: tb/range_booth_mul_tb.sv
module range_booth_mul_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        out_valid;
  logic [1:0]  out_prec;
  logic [31:0] out_prod;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  logic        h_v [4];
  logic [31:0] h_p [4];
  logic [1:0]  h_m [4];
  logic [31:0] last_p = '0;
  logic [1:0]  last_m = 2'd0;

  always #5 clk = ~clk;

  range_booth_mul u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_prec(out_prec), .out_prod(out_prod)
  );

  function automatic bit fits(logic [15:0] x, int n);
    int v = int'($signed(x));
    return (v >= -(1 << (n - 1))) && (v < (1 << (n - 1)));
  endfunction

  function automatic logic [1:0] exp_prec(logic [15:0] a, logic [15:0] b);
    if (fits(a, 4) && fits(b, 4)) return 2'd0;
    if (fits(a, 8) && fits(b, 8)) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [31:0] exp_prod(logic [15:0] a, logic [15:0] b);
    return 32'(int'($signed(a)) * int'($signed(b)));
  endfunction

  function automatic logic [15:0] mk(int cls, logic [31:0] r);
    case (cls)
      0:       return {{12{r[3]}}, r[3:0]};
      1:       return {{8{r[7]}}, r[7:0]};
      default: return r[15:0];
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // at each falling edge: check the op driven three cycles ago, then drive the next one
  task automatic step(bit v, logic [15:0] a, logic [15:0] b);
    int k;
    @(negedge clk);
    k = (cyc + 1) % 4;
    chk(out_valid == h_v[k], "R2/R6 valid", 32'(out_valid), 32'(h_v[k]));
    if (h_v[k]) begin
      if (h_m[k] == 2'd2) chk(out_prod == h_p[k], "R1 product", out_prod, h_p[k]);
      else                chk(out_prod == h_p[k], "R1/R7 narrow product", out_prod, h_p[k]);
      case (h_m[k])
        2'd0:    chk(out_prec == 2'd0, "R3 prec", 32'(out_prec), 32'(h_m[k]));
        2'd1:    chk(out_prec == 2'd1, "R4 prec", 32'(out_prec), 32'(h_m[k]));
        default: chk(out_prec == 2'd2, "R5 prec", 32'(out_prec), 32'(h_m[k]));
      endcase
      last_p = h_p[k];
      last_m = h_m[k];
    end else begin
      chk(out_prod == last_p && out_prec == last_m, "R9 hold", out_prod, last_p);
    end
    in_valid = v;
    op_a = a;
    op_b = b;
    h_v[cyc % 4] = v;
    h_p[cyc % 4] = exp_prod(a, b);
    h_m[cyc % 4] = exp_prec(a, b);
    cyc++;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      h_v[i] = 1'b0; h_p[i] = '0; h_m[i] = 2'd0;
    end
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 valid", 32'(out_valid), 0);
    chk(out_prec == 2'd0, "R8 prec", 32'(out_prec), 0);
    chk(out_prod == 32'd0, "R8 product", out_prod, 0);
    rst = 1'b0;

    // directed corners
    step(1, 16'd0, 16'd0);
    step(1, 16'd7, 16'hFFF8);
    step(1, 16'hFFF8, 16'hFFF8);
    step(1, 16'd8, 16'd1);
    step(1, 16'd127, 16'hFF80);
    step(1, 16'hFF80, 16'hFF80);
    step(0, 16'h1234, 16'h5678);
    step(1, 16'd128, 16'd1);
    step(1, 16'd7, 16'd128);
    step(1, 16'h8000, 16'h8000);
    step(1, 16'h8000, 16'h7FFF);
    step(1, 16'h7FFF, 16'h7FFF);
    step(1, 16'hFFFF, 16'h0005);
    step(0, 16'd0, 16'd0);
    step(0, 16'd0, 16'd0);
    step(1, 16'd3, 16'h00F0);
    step(1, 16'h0100, 16'hFFFF);

    // random, mixed ranges, mostly back to back
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r1 = $urandom;
      logic [31:0] r2 = $urandom;
      int ca = int'(r1[31:30]) % 3;
      int cb = int'(r2[31:30]) % 3;
      step(r1[29:27] != 3'd0, mk(ca, r1), mk(cb, r2));
    end
    repeat (4) step(0, 16'd0, 16'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule